// File: doc/BRIEF.md
# Clock Source Mode Switch Controller

This controller decides which of three clock sources drives the device: the primary crystal oscillator, a slow low-power internal source, or a fast internal source with several selectable speeds. Mode-select, speed-select and a fast-source request arrive as plain inputs. The block then drives the oscillator enables and a one-hot code that names the source now in use. A downstream glitch-free multiplexer consumes that code, so the block itself carries no clock.

Moving to internal operation takes effect at once. The primary oscillator is switched off and its stability flag drops. Moving back is a handoff. The device keeps running on the internal source while the primary oscillator restarts. The switch happens only after a start-up timer has counted a fixed number of primary oscillator periods, followed by an optional lock wait for a frequency multiplier that is counted in reference ticks.

A second timer tracks how long the fast internal source has been running. Its stability flag only asserts after a settling interval. If the source was already settled when internal mode is entered, the flag asserts straight away.

Top module: `clkmode_switch`

## Requirements
- R1: While `rst_n` is low, `src_onehot` is 3'b001, `pri_osc_en` is 1, and `fast_osc_en`, `slow_osc_en`, `pri_stable` and `fast_stable` are all 0.
- R2: All outputs are registered and react one clock after the inputs are sampled. If `src_sel[1]` is 1 at an edge, then after that edge `pri_osc_en` is 0, `pri_stable` is 0 and `src_onehot[0]` is 0. `src_sel[0]` has no effect on any output.
- R3: A source request is present when `freq_sel` is non-zero or `fast_src_req` is 1. Without a request, `fast_osc_en` and `fast_stable` are 0, and in internal mode `src_onehot` is 3'b010 (slow source).
- R4: With a request present, `fast_osc_en` is 1 one clock later, and in internal mode `src_onehot` is 3'b100. The settling count starts at the first edge with the request. `fast_stable` rises one edge after `STAB_TICKS` reference ticks have been counted with `freq_sel` held steady. It is only ever 1 while `fast_osc_en` is 1 and `src_onehot[0]` is 0.
- R5: If the fast source has already settled in primary mode, `fast_stable` becomes 1 in the same cycle that `src_onehot` switches to 3'b100.
- R6: Once settled, changes of `freq_sel` between non-zero values leave `fast_stable` at 1. Before settling, any change of `freq_sel` restarts the settling count.
- R7: When `src_sel[1]` drops, `pri_osc_en` is 1 one clock later and the code stays internal. The start-up timer counts `OST_PERIODS` cycles with `pri_osc_tick` high. With `USE_PLL` set, it then counts `PLL_LOCK_TICKS` cycles with `ref_tick` high. The switch follows on the next edge. With both ticks held high, `src_onehot` becomes 3'b001 exactly `OST_PERIODS + PLL_LOCK_TICKS + 2` edges after the drop.
- R8: In the cycle the switch to primary completes, `pri_stable` is 1 and `fast_stable` is 0.
- R9: Raising `src_sel[1]` again before the handoff completes aborts it. A later handoff starts counting from zero.
- R10: `slow_osc_en` is 1 one clock after any edge at which `wdt_en` or `fscm_en` is 1, whichever source is selected. It is also 1 whenever the slow source is selected.
- R11: `src_onehot` always has exactly one bit set.
- R12: After reset the start-up timer runs in primary mode. With both ticks held high, `pri_stable` rises `OST_PERIODS + PLL_LOCK_TICKS + 1` edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference tick for the settling and lock counters |
| pri_osc_tick | input | 1 | One pulse per primary oscillator period |
| src_sel | input | 2 | Source select; bit 1 chooses internal mode, bit 0 is ignored |
| freq_sel | input | FSEL_W | Fast internal speed select; zero means no fast request |
| fast_src_req | input | 1 | Forces the fast internal source on |
| wdt_en | input | 1 | Watchdog enabled; keeps the slow source running |
| fscm_en | input | 1 | Fail-safe clock monitor enabled; keeps the slow source running |
| pri_osc_en | output | 1 | Primary oscillator enable |
| slow_osc_en | output | 1 | Slow internal source enable |
| fast_osc_en | output | 1 | Fast internal source enable |
| src_onehot | output | 3 | Source in use: bit 0 primary, bit 1 slow, bit 2 fast |
| pri_stable | output | 1 | Primary running and past its start-up timer |
| fast_stable | output | 1 | Fast source settled and feeding the device |

## Verification
The bench builds the block with `FSEL_W` 3, `OST_PERIODS` 8, `USE_PLL` 1, `PLL_LOCK_TICKS` 5 and `STAB_TICKS` 6. With these values a full handoff, including the lock stage, takes only about a dozen edges. Random select changes that arrive every few dozen cycles therefore land as often before completion (aborts) as after it. The settling interval is short enough that speed changes often hit both the restart window and the settled window.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

   typedef enum logic [1:0] {
      MODE_PRI     = 2'd0,
      MODE_INT     = 2'd1,
      MODE_HANDOFF = 2'd2
   } mode_e;

   localparam int SRC_W    = 3;
   localparam int SRC_PRI  = 0;
   localparam int SRC_SLOW = 1;
   localparam int SRC_FAST = 2;

   function automatic logic [SRC_W-1:0] src_code(input mode_e m, input logic fast);
      logic [SRC_W-1:0] r;
      r = '0;
      if (m == MODE_PRI)
         r[SRC_PRI] = 1'b1;
      else if (fast)
         r[SRC_FAST] = 1'b1;
      else
         r[SRC_SLOW] = 1'b1;
      return r;
   endfunction

endpackage

// File: rtl/clkmode_startup.sv
module clkmode_startup #(
   parameter int OST_PERIODS    = 1024,
   parameter bit USE_PLL        = 1'b0,
   parameter int PLL_LOCK_TICKS = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic pri_tick_i,
   input  logic ref_tick_i,
   output logic done_o
);
   localparam int               OST_W    = $clog2(OST_PERIODS + 1);
   localparam logic [OST_W-1:0] OST_LAST = OST_W'(OST_PERIODS - 1);

   logic [OST_W-1:0] ost_cnt;
   logic             ost_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ost_cnt  <= '0;
         ost_done <= 1'b0;
      end else if (!run_i) begin
         ost_cnt  <= '0;
         ost_done <= 1'b0;
      end else if (!ost_done && pri_tick_i) begin
         if (ost_cnt == OST_LAST)
            ost_done <= 1'b1;
         else
            ost_cnt <= ost_cnt + 1'b1;
      end
   end

   generate
      if (USE_PLL) begin : g_lock
         localparam int               LCK_W    = $clog2(PLL_LOCK_TICKS + 1);
         localparam logic [LCK_W-1:0] LCK_LAST = LCK_W'(PLL_LOCK_TICKS - 1);
         logic [LCK_W-1:0] lock_cnt;
         logic             lock_done;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lock_cnt  <= '0;
               lock_done <= 1'b0;
            end else if (!run_i || !ost_done) begin
               lock_cnt  <= '0;
               lock_done <= 1'b0;
            end else if (!lock_done && ref_tick_i) begin
               if (lock_cnt == LCK_LAST)
                  lock_done <= 1'b1;
               else
                  lock_cnt <= lock_cnt + 1'b1;
            end
         end
         assign done_o = lock_done;
      end else begin : g_nolock
         logic unused_ref;
         assign unused_ref = ref_tick_i;
         assign done_o     = ost_done;
      end
   endgenerate

endmodule

// File: rtl/clkmode_stab.sv
module clkmode_stab #(
   parameter int FSEL_W     = 3,
   parameter int STAB_TICKS = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              on_i,
   input  logic [FSEL_W-1:0] sel_i,
   input  logic              ref_tick_i,
   output logic              ready_o
);
   localparam int              ST_W    = $clog2(STAB_TICKS + 1);
   localparam logic [ST_W-1:0] ST_LAST = ST_W'(STAB_TICKS - 1);

   logic [ST_W-1:0]   st_cnt;
   logic [FSEL_W-1:0] sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_cnt  <= '0;
         ready_o <= 1'b0;
         sel_q   <= '0;
      end else begin
         sel_q <= sel_i;
         if (!on_i) begin
            st_cnt  <= '0;
            ready_o <= 1'b0;
         end else if (!ready_o) begin
            if (sel_i != sel_q)
               st_cnt <= '0;
            else if (ref_tick_i) begin
               if (st_cnt == ST_LAST)
                  ready_o <= 1'b1;
               else
                  st_cnt <= st_cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/clkmode_fsm.sv
module clkmode_fsm
   import clkmode_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             int_req_i,
   input  logic             fast_want_i,
   input  logic             su_done_i,
   input  logic             fast_rdy_i,
   input  logic             keep_slow_i,
   output logic             run_su_o,
   output logic             pri_en_o,
   output logic             fast_en_o,
   output logic             slow_en_o,
   output logic [SRC_W-1:0] src_o,
   output logic             osts_o,
   output logic             iofs_o
);
   mode_e            mode_q, mode_n;
   logic [SRC_W-1:0] src_n;

   always_comb begin
      mode_n = mode_q;
      unique case (mode_q)
         MODE_PRI:     if (int_req_i) mode_n = MODE_INT;
         MODE_INT:     if (!int_req_i) mode_n = MODE_HANDOFF;
         MODE_HANDOFF: begin
            if (int_req_i)
               mode_n = MODE_INT;
            else if (su_done_i)
               mode_n = MODE_PRI;
         end
         default:      mode_n = MODE_PRI;
      endcase
   end

   assign src_n    = src_code(mode_n, fast_want_i);
   assign run_su_o = (mode_q != MODE_INT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= MODE_PRI;
         pri_en_o  <= 1'b1;
         fast_en_o <= 1'b0;
         slow_en_o <= 1'b0;
         src_o     <= SRC_W'(1) << SRC_PRI;
         osts_o    <= 1'b0;
         iofs_o    <= 1'b0;
      end else begin
         mode_q    <= mode_n;
         pri_en_o  <= (mode_n != MODE_INT);
         fast_en_o <= fast_want_i;
         slow_en_o <= keep_slow_i | src_n[SRC_SLOW];
         src_o     <= src_n;
         osts_o    <= (mode_n == MODE_PRI) && su_done_i;
         iofs_o    <= (mode_n != MODE_PRI) && fast_rdy_i && fast_want_i;
      end
   end

endmodule

// File: rtl/clkmode_switch.sv
module clkmode_switch #(
   parameter int FSEL_W         = 3,
   parameter int OST_PERIODS    = 1024,
   parameter bit USE_PLL        = 1'b0,
   parameter int PLL_LOCK_TICKS = 2000,
   parameter int STAB_TICKS     = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              pri_osc_tick,
   input  logic [1:0]        src_sel,
   input  logic [FSEL_W-1:0] freq_sel,
   input  logic              fast_src_req,
   input  logic              wdt_en,
   input  logic              fscm_en,
   output logic              pri_osc_en,
   output logic              slow_osc_en,
   output logic              fast_osc_en,
   output logic [2:0]        src_onehot,
   output logic              pri_stable,
   output logic              fast_stable
);
   generate
      if (FSEL_W < 1) begin : g_bad_fsel
         $error("clkmode_switch: FSEL_W must be at least 1");
      end
      if (OST_PERIODS < 1) begin : g_bad_ost
         $error("clkmode_switch: OST_PERIODS must be at least 1");
      end
      if (STAB_TICKS < 1) begin : g_bad_stab
         $error("clkmode_switch: STAB_TICKS must be at least 1");
      end
      if (USE_PLL && PLL_LOCK_TICKS < 1) begin : g_bad_lock
         $error("clkmode_switch: PLL_LOCK_TICKS must be at least 1");
      end
   endgenerate

   logic fast_want, int_req, su_run, su_done, fast_rdy, keep_slow;
   logic unused_sel0;

   assign fast_want   = (|freq_sel) | fast_src_req;
   assign int_req     = src_sel[1];
   assign keep_slow   = wdt_en | fscm_en;
   assign unused_sel0 = src_sel[0];

   clkmode_startup #(
      .OST_PERIODS   (OST_PERIODS),
      .USE_PLL       (USE_PLL),
      .PLL_LOCK_TICKS(PLL_LOCK_TICKS)
   ) u_startup (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (su_run),
      .pri_tick_i(pri_osc_tick),
      .ref_tick_i(ref_tick),
      .done_o    (su_done)
   );

   clkmode_stab #(
      .FSEL_W    (FSEL_W),
      .STAB_TICKS(STAB_TICKS)
   ) u_stab (
      .clk       (clk),
      .rst_n     (rst_n),
      .on_i      (fast_want),
      .sel_i     (freq_sel),
      .ref_tick_i(ref_tick),
      .ready_o   (fast_rdy)
   );

   clkmode_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .int_req_i  (int_req),
      .fast_want_i(fast_want),
      .su_done_i  (su_done),
      .fast_rdy_i (fast_rdy),
      .keep_slow_i(keep_slow),
      .run_su_o   (su_run),
      .pri_en_o   (pri_osc_en),
      .fast_en_o  (fast_osc_en),
      .slow_en_o  (slow_osc_en),
      .src_o      (src_onehot),
      .osts_o     (pri_stable),
      .iofs_o     (fast_stable)
   );

endmodule

// File: rtl/clkmode_switch_chk.sv
module clkmode_switch_chk #(
   parameter int FSEL_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_int,
   input logic [FSEL_W-1:0] freq_sel,
   input logic              fast_src_req,
   input logic              wdt_en,
   input logic              fscm_en,
   input logic              pri_osc_en,
   input logic              slow_osc_en,
   input logic              fast_osc_en,
   input logic [2:0]        src_onehot,
   input logic              pri_stable,
   input logic              fast_stable
);
   p_one_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(src_onehot) == 1);

   p_pri_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_int |=> (!pri_osc_en && !pri_stable && !src_onehot[0]));

   p_pri_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_int |=> pri_osc_en);

   p_slow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_en || fscm_en) |=> slow_osc_en);

   p_fast_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_sel == '0 && !fast_src_req) |=> (!fast_osc_en && !fast_stable));

   p_fast_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fast_stable |-> (fast_osc_en && !src_onehot[0]));

   p_handoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(src_onehot[0]) |-> (pri_stable && !fast_stable));

endmodule

bind clkmode_switch clkmode_switch_chk #(.FSEL_W(FSEL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sel_int     (src_sel[1]),
   .freq_sel    (freq_sel),
   .fast_src_req(fast_src_req),
   .wdt_en      (wdt_en),
   .fscm_en     (fscm_en),
   .pri_osc_en  (pri_osc_en),
   .slow_osc_en (slow_osc_en),
   .fast_osc_en (fast_osc_en),
   .src_onehot  (src_onehot),
   .pri_stable  (pri_stable),
   .fast_stable (fast_stable)
);

// File: tb/clkmode_switch_test.sv
`timescale 1ns/1ps
module clkmode_switch_test;
   localparam int FSEL_W = 3;
   localparam int OST    = 8;
   localparam bit PLL    = 1'b1;
   localparam int LOCK   = 5;
   localparam int STAB   = 6;

   logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0, pri_osc_tick = 1'b0;
   logic fast_src_req = 1'b0, wdt_en = 1'b0, fscm_en = 1'b0;
   logic [1:0]        src_sel  = 2'b00;
   logic [FSEL_W-1:0] freq_sel = '0;
   logic pri_osc_en, slow_osc_en, fast_osc_en, pri_stable, fast_stable;
   logic [2:0] src_onehot;

   int tests = 0, fails = 0, n;
   bit chk_on = 1'b0;

   always #4 clk = ~clk;

   clkmode_switch #(.FSEL_W(FSEL_W), .OST_PERIODS(OST), .USE_PLL(PLL),
                    .PLL_LOCK_TICKS(LOCK), .STAB_TICKS(STAB)) uut (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pri_osc_tick(pri_osc_tick),
      .src_sel(src_sel), .freq_sel(freq_sel), .fast_src_req(fast_src_req),
      .wdt_en(wdt_en), .fscm_en(fscm_en), .pri_osc_en(pri_osc_en),
      .slow_osc_en(slow_osc_en), .fast_osc_en(fast_osc_en), .src_onehot(src_onehot),
      .pri_stable(pri_stable), .fast_stable(fast_stable));

   task automatic check(input bit ok, input string what, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   // behavioural model of the requirements, stepped on each edge
   int m_mode, m_ost_cnt, m_lock_cnt, m_fcnt;
   bit m_ost_done, m_lock_done, m_rdy;
   bit m_pri_en, m_fast_en, m_slow_en, m_osts, m_iofs;
   logic [FSEL_W-1:0] m_fs_q;
   logic [2:0] m_src;

   always @(posedge clk or negedge rst_n) begin : model
      bit want, su_run, su_done_old, rdy_old, ost_done_old;
      int nm;
      if (!rst_n) begin
         m_mode = 0; m_ost_cnt = 0; m_lock_cnt = 0; m_fcnt = 0;
         m_ost_done = 0; m_lock_done = 0; m_rdy = 0; m_fs_q = '0;
         m_pri_en = 1; m_fast_en = 0; m_slow_en = 0; m_osts = 0; m_iofs = 0;
         m_src = 3'b001;
      end else begin
         want         = (freq_sel != '0) || fast_src_req;
         su_run       = (m_mode != 1);
         su_done_old  = PLL ? m_lock_done : m_ost_done;
         rdy_old      = m_rdy;
         ost_done_old = m_ost_done;
         if (!su_run) begin m_ost_cnt = 0; m_ost_done = 0; end
         else if (!m_ost_done && pri_osc_tick) begin
            if (m_ost_cnt == OST - 1) m_ost_done = 1; else m_ost_cnt++;
         end
         if (!su_run || !ost_done_old) begin m_lock_cnt = 0; m_lock_done = 0; end
         else if (!m_lock_done && ref_tick) begin
            if (m_lock_cnt == LOCK - 1) m_lock_done = 1; else m_lock_cnt++;
         end
         if (!want) begin m_fcnt = 0; m_rdy = 0; end
         else if (!m_rdy) begin
            if (freq_sel != m_fs_q) m_fcnt = 0;
            else if (ref_tick) begin
               if (m_fcnt == STAB - 1) m_rdy = 1; else m_fcnt++;
            end
         end
         m_fs_q = freq_sel;
         nm = m_mode;
         case (m_mode)
            0:       if (src_sel[1]) nm = 1;
            1:       if (!src_sel[1]) nm = 2;
            default: if (src_sel[1]) nm = 1; else if (su_done_old) nm = 0;
         endcase
         m_mode    = nm;
         m_pri_en  = (nm != 1);
         m_src     = (nm == 0) ? 3'b001 : (want ? 3'b100 : 3'b010);
         m_osts    = (nm == 0) && su_done_old;
         m_iofs    = (nm != 0) && rdy_old && want;
         m_fast_en = want;
         m_slow_en = wdt_en || fscm_en || m_src[1];
      end
   end

   always @(negedge clk) begin
      if (chk_on) begin
         check(pri_osc_en === m_pri_en, "R2 R7 pri_osc_en", pri_osc_en, m_pri_en);
         check(src_onehot === m_src, "R7 R11 src_onehot", src_onehot, m_src);
         check(pri_stable === m_osts, "R8 R12 pri_stable", pri_stable, m_osts);
         check(fast_stable === m_iofs, "R4 R5 R6 fast_stable", fast_stable, m_iofs);
         check(fast_osc_en === m_fast_en, "R3 fast_osc_en", fast_osc_en, m_fast_en);
         check(slow_osc_en === m_slow_en, "R10 slow_osc_en", slow_osc_en, m_slow_en);
      end
   end

   task automatic edges(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", 150000, 0);
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      edges(3);
      // R1 reset state
      check(src_onehot == 3'b001, "R1 src_onehot", src_onehot, 1);
      check(pri_osc_en == 1'b1, "R1 pri_osc_en", pri_osc_en, 1);
      check({fast_osc_en, slow_osc_en, pri_stable, fast_stable} == 4'b0,
            "R1 flags", {fast_osc_en, slow_osc_en, pri_stable, fast_stable}, 0);
      ref_tick = 1; pri_osc_tick = 1; chk_on = 1; rst_n = 1;
      // R12 start-up after reset
      n = 0;
      while (!pri_stable && n < 200) begin @(posedge clk); n++; @(negedge clk); end
      check(n == OST + LOCK + 1, "R12 edges to pri_stable", n, OST + LOCK + 1);
      // R2 internal entry, lower bit ignored
      src_sel = 2'b11; edges(1);
      check(!pri_osc_en && !pri_stable && src_onehot == 3'b010, "R2 entry",
            {pri_osc_en, pri_stable, src_onehot}, 3'b00010);
      src_sel = 2'b10; edges(1);
      check(src_onehot == 3'b010 && !pri_osc_en, "R2 bit0 ignored", src_onehot, 3'b010);
      src_sel = 2'b11; edges(1);
      check(src_onehot == 3'b010 && !pri_osc_en, "R2 bit0 ignored", src_onehot, 3'b010);
      // R3 no fast request
      edges(3);
      check(!fast_osc_en && !fast_stable, "R3 fast off", {fast_osc_en, fast_stable}, 0);
      // R4 settling
      freq_sel = 3; n = 0;
      @(posedge clk); n++; @(negedge clk);
      check(fast_osc_en && src_onehot == 3'b100, "R4 fast on", src_onehot, 3'b100);
      while (!fast_stable && n < 200) begin @(posedge clk); n++; @(negedge clk); end
      check(n == STAB + 2, "R4 edges to fast_stable", n, STAB + 2);
      // R6 speed change after settling
      freq_sel = 5;
      for (int i = 0; i < 3; i++) begin
         edges(1);
         check(fast_stable == 1'b1, "R6 settled speed change", fast_stable, 1);
      end
      // R7 R8 handoff
      src_sel = 2'b00; n = 0;
      while (!src_onehot[0] && n < 200) begin
         @(posedge clk); n++; @(negedge clk);
         check(pri_osc_en == 1'b1, "R7 primary enabled in handoff", pri_osc_en, 1);
      end
      check(n == OST + LOCK + 2, "R7 edges to primary", n, OST + LOCK + 2);
      check(pri_stable && !fast_stable, "R8 flags at switch", {pri_stable, fast_stable}, 2);
      // R5 fast already settled
      edges(2);
      src_sel = 2'b10; edges(1);
      check(src_onehot == 3'b100 && fast_stable, "R5 immediate fast_stable",
            {src_onehot, fast_stable}, 4'b1001);
      // R9 abort then restart
      src_sel = 2'b00; edges(4);
      src_sel = 2'b10; edges(2);
      check(!src_onehot[0], "R9 aborted handoff", src_onehot, 3'b100);
      src_sel = 2'b00; n = 0;
      while (!src_onehot[0] && n < 200) begin @(posedge clk); n++; @(negedge clk); end
      check(n == OST + LOCK + 2, "R9 restarted count", n, OST + LOCK + 2);
      // R6 restart during settling
      src_sel = 2'b10; freq_sel = 0; edges(2);
      freq_sel = 1; edges(3);
      check(!fast_stable, "R6 not yet settled", fast_stable, 0);
      freq_sel = 2; n = 0;
      while (!fast_stable && n < 200) begin @(posedge clk); n++; @(negedge clk); end
      check(n == STAB + 2, "R6 restart edges", n, STAB + 2);
      // R10 slow source kept alive
      wdt_en = 1; edges(1);
      check(slow_osc_en == 1'b1, "R10 watchdog", slow_osc_en, 1);
      wdt_en = 0; fscm_en = 1; edges(1);
      check(slow_osc_en == 1'b1, "R10 monitor", slow_osc_en, 1);
      fscm_en = 0; edges(1);
      check(slow_osc_en == 1'b0, "R10 released", slow_osc_en, 0);
      // random phase
      for (int c = 0; c < 4000; c++) begin
         ref_tick     = $urandom_range(1, 0);
         pri_osc_tick = ($urandom_range(3, 0) != 0);
         if ($urandom_range(39, 0) == 0) src_sel = 2'($urandom_range(3, 0));
         if ($urandom_range(24, 0) == 0)
            freq_sel = $urandom_range(1, 0) ? '0 : FSEL_W'($urandom_range(7, 0));
         if ($urandom_range(29, 0) == 0) fast_src_req = ~fast_src_req;
         if ($urandom_range(59, 0) == 0) begin
            wdt_en  = $urandom_range(1, 0);
            fscm_en = $urandom_range(1, 0);
         end
         edges(1);
      end
      summary();
      $finish;
   end
endmodule